// File: doc/BRIEF.md
# Serial Horner Multiplier

This block multiplies a parallel two's complement fractional multiplicand by a multiplier that arrives one bit per clock, least significant bit first. Each incoming multiplier bit either adds the multiplicand to a running partial sum or adds nothing. The partial sum is then halved with an arithmetic right shift, so the product is built by Horner's rule. The multiplier's sign bit arrives last and carries negative weight. For that bit the multiplicand is subtracted, by adding its bitwise inverse with a carry-in of one. Only the upper W bits of the full product are kept, so the result has the same word length as the operands.

Halving a stream that arrives LSB first cannot be done causally: the output bit for one weight would depend on input bits that have not yet arrived. The block therefore accumulates the whole word before emitting anything. It then shifts the W-bit result out LSB first, starting exactly W clocks after the input word began, with a pulse marking result bit 0. Words may follow each other with no gap.

Top module: `serial_horner_mul`

## Requirements
- R1: For multiplicand A and multiplier B, read as W-bit two's complement integers, the output word equals the low W bits of floor(A*B / 2^(W-1)). For example, with W=8, A=B=-128 gives 0x80, and A=-1, B=1 gives 0xFF.
- R2: A word opens in the cycle where `in_start` is 1. `in_bit` carries multiplier bit k in the k-th cycle of the word, counting from 0 at the start cycle. `mcand` is sampled only in the start cycle, and its value in later cycles of the word has no effect.
- R3: `out_start` is 1 exactly W cycles after the `in_start` of a complete word. In that cycle and the W-1 cycles that follow, `out_bit` presents the result LSB first, one bit per cycle.
- R4: Words may be presented back to back, with a new `in_start` in the cycle after the previous word's last bit. Every complete word then yields its own result word, and no result word is cut short.
- R5: Multiplier bit W-1 has weight -2^(W-1), so a set sign bit subtracts the multiplicand (A=5, B=-128 gives -5).
- R6: Bits presented while no word is open are ignored: `out_start` stays 0 and `out_bit` stays 0.
- R7: An `in_start` that arrives before the current word's last bit abandons that word. The abandoned word produces no output, and only the newly opened word yields a result.
- R8: While `rst` is high and in the cycle after it falls, `out_bit` and `out_start` are 0. A word that is open when reset asserts produces no output.
- R9: Once the W bits of a result word have been presented, `out_bit` is 0 until the next `out_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_start | input | 1 | Marks bit 0 of a multiplier word |
| in_bit | input | 1 | Serial multiplier bit, LSB first |
| mcand | input | W | Parallel multiplicand, sampled with `in_start` |
| out_bit | output | 1 | Serial product bit, LSB first |
| out_start | output | 1 | Marks bit 0 of a product word |

## Verification
Directed operand pairs target the sign handling:
- The most negative value squared shows the single wrap case.
- A multiplier of only its sign bit isolates the subtract step from the additions.
- Small negative operands show floor rounding rather than truncation toward zero.

Random pairs sent back to back, with the multiplicand port scrambled after each start cycle, show that each word uses its own latched multiplicand and the correct bit alignment. Three further cases check which words produce output and which do not:
- a stream with no word open,
- a word restarted partway through,
- a word cut off by reset.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_e;

endpackage

// File: rtl/bsm_word_ctrl.sv
// Tracks the bit position inside the current multiplier word.
module bsm_word_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_start,
  output logic step_valid,
  output logic step_first,
  output logic step_last
);
  localparam int CW = $clog2(W + 1);

  logic          open_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] cur_idx;

  always_comb begin
    cur_idx    = in_start ? '0 : idx_q;
    step_valid = in_start | open_q;
    step_first = in_start;
    step_last  = step_valid && (cur_idx == CW'(W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      idx_q  <= '0;
    end else if (step_valid) begin
      open_q <= ~step_last;
      idx_q  <= cur_idx + CW'(1);
    end
  end
endmodule

// File: rtl/bsm_addsub.sv
// Ripple-carry adder; subtraction adds the inverted operand with carry-in 1.
module bsm_addsub
  import bsm_pkg::*;
#(
  parameter int N = 9
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  addsub_e      mode_i,
  output logic [N-1:0] sum_o
);
  logic [N-1:0] carry;
  logic [N-1:0] b_x;

  assign carry[0] = (mode_i == OP_SUB);
  assign b_x      = b_i ^ {N{carry[0]}};

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_x[i] ^ carry[i];
    if (i < N - 1) begin : g_c
      assign carry[i+1] = (a_i[i] & b_x[i]) | (carry[i] & (a_i[i] ^ b_x[i]));
    end
  end
endmodule

// File: rtl/bsm_horner_acc.sv
// Horner accumulator: sum = (sum + A*b)/2 per bit, last bit subtracts A.
module bsm_horner_acc
  import bsm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_valid,
  input  logic         step_first,
  input  logic         step_last,
  input  logic         in_bit,
  input  logic [W-1:0] mcand,
  output logic         res_load,
  output logic [W-1:0] res_word
);
  localparam int AW = W + 1;

  logic [W-1:0]  a_q;
  logic [W-1:0]  a_cur;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] part;
  logic [AW-1:0] term;
  logic [AW-1:0] sum;
  addsub_e       mode;

  always_comb begin
    a_cur    = step_first ? mcand : a_q;
    part     = step_first ? '0 : acc_q;
    term     = in_bit ? {a_cur[W-1], a_cur} : '0;
    mode     = step_last ? OP_SUB : OP_ADD;
    res_load = step_valid & step_last;
    res_word = sum[W-1:0];
  end

  bsm_addsub #(.N(AW)) u_add (
    .a_i    (part),
    .b_i    (term),
    .mode_i (mode),
    .sum_o  (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      acc_q <= '0;
    end else begin
      if (step_first) a_q <= mcand;
      if (step_valid && !step_last) acc_q <= {sum[AW-1], sum[AW-1:1]};
    end
  end
endmodule

// File: rtl/bsm_out_ser.sv
// Registered parallel-to-serial stage for the result word.
module bsm_out_ser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         out_bit,
  output logic         out_start
);
  logic [W-1:0] sh_q;
  logic         st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      st_q <= 1'b0;
    end else begin
      st_q <= load;
      if (load) sh_q <= word;
      else      sh_q <= {1'b0, sh_q[W-1:1]};
    end
  end

  assign out_bit   = sh_q[0];
  assign out_start = st_q;
endmodule

// File: rtl/serial_horner_mul.sv
module serial_horner_mul #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_start,
  input  logic         in_bit,
  input  logic [W-1:0] mcand,
  output logic         out_bit,
  output logic         out_start
);
  logic         step_valid;
  logic         step_first;
  logic         step_last;
  logic         res_load;
  logic [W-1:0] res_word;

  bsm_word_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .in_start   (in_start),
    .step_valid (step_valid),
    .step_first (step_first),
    .step_last  (step_last)
  );

  bsm_horner_acc #(.W(W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .step_valid (step_valid),
    .step_first (step_first),
    .step_last  (step_last),
    .in_bit     (in_bit),
    .mcand      (mcand),
    .res_load   (res_load),
    .res_word   (res_word)
  );

  bsm_out_ser #(.W(W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .load      (res_load),
    .word      (res_word),
    .out_bit   (out_bit),
    .out_start (out_start)
  );
endmodule

// File: rtl/serial_horner_mul_chk.sv
module serial_horner_mul_chk #(
  parameter int W = 8
) (
  input logic clk,
  input logic rst,
  input logic in_start,
  input logic out_start,
  input logic out_bit
);
  localparam int CW = $clog2(W + 2);

  logic [CW-1:0] since_in;
  logic [CW-1:0] since_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_in  <= CW'(W + 1);
      since_out <= CW'(W);
    end else begin
      if (in_start)                    since_in <= CW'(1);
      else if (since_in < CW'(W + 1))  since_in <= since_in + CW'(1);
      if (out_start)                   since_out <= CW'(1);
      else if (since_out < CW'(W))     since_out <= since_out + CW'(1);
    end
  end

  // R3
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_start |-> (since_in == CW'(W)));

  // R3
  word_done_chk: assert property (@(posedge clk) disable iff (rst)
    (since_in == CW'(W - 1) && !in_start) |=> out_start);

  // R4
  out_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    out_start |=> !out_start);

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_start && !out_bit));

  // R9
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (since_out >= CW'(W) && !out_start) |-> !out_bit);
endmodule

bind serial_horner_mul serial_horner_mul_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_start  (in_start),
  .out_start (out_start),
  .out_bit   (out_bit)
);

// File: tb/serial_horner_mul_tb.sv
module serial_horner_mul_tb;
  localparam int W  = 8;
  localparam int NV = 16;
  localparam int MAXW = 128;

  // {A, B}
  localparam logic [15:0] VEC [NV] = '{
    16'h0000, 16'h7F7F, 16'h8080, 16'h807F,
    16'h7F80, 16'h0180, 16'h0580, 16'hFFFF,
    16'hFF01, 16'h4040, 16'hC040, 16'h55AA,
    16'h1234, 16'h8001, 16'h8181, 16'h7F01
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_start;
  logic         in_bit;
  logic [W-1:0] mcand;
  logic         out_bit;
  logic         out_start;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int n_sent = 0;
  int n_recv = 0;
  int bitpos = 0;
  logic [W-1:0] rbuf;
  logic [W-1:0] exp_word [MAXW];
  int           start_cyc [MAXW];

  serial_horner_mul #(.W(W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_start  (in_start),
    .in_bit    (in_bit),
    .mcand     (mcand),
    .out_bit   (out_bit),
    .out_start (out_start)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_mul(input logic signed [W-1:0] a,
                                           input logic signed [W-1:0] b);
    int p;
    p = int'(a) * int'(b);
    p = p >>> (W - 1);
    return p[W-1:0];
  endfunction

  // R1 R3 R4: collect and compare every result word
  always @(negedge clk) begin
    if (rst) begin
      bitpos = 0;
    end else begin
      if (out_start) begin
        if (bitpos != 0) chk(1'b0, "R4 result word cut short", bitpos, W);
        rbuf = '0;
        rbuf[0] = out_bit;
        bitpos = 1;
        if (n_recv < n_sent)
          chk(cyc == start_cyc[n_recv] + W, "R3 output latency", cyc, start_cyc[n_recv] + W);
        else
          chk(1'b0, "R6 R7 R8 unexpected out_start", n_recv, n_sent);
      end else if (bitpos != 0) begin
        rbuf[bitpos] = out_bit;
        bitpos++;
      end
      if (bitpos == W) begin
        if (n_recv < n_sent) begin
          chk(rbuf == exp_word[n_recv], "R1 R5 product word", int'(rbuf), int'(exp_word[n_recv]));
          n_recv++;
        end
        bitpos = 0;
      end
    end
  end

  // R2: mcand is scrambled after the start cycle
  task automatic send_word(input logic [W-1:0] a, input logic [W-1:0] b);
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      in_start = (k == 0);
      in_bit   = b[k];
      mcand    = (k == 0) ? a : ~a;
      if (k == 0) begin
        start_cyc[n_sent] = cyc;
        exp_word[n_sent]  = ref_mul(a, b);
        n_sent++;
      end
    end
  endtask

  task automatic send_partial(input int nb);
    for (int k = 0; k < nb; k++) begin
      @(negedge clk);
      in_start = (k == 0);
      in_bit   = 1'b1;
      mcand    = 8'h6B;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_start = 1'b0;
      in_bit   = 1'($urandom);
      mcand    = W'($urandom);
    end
  endtask

  task automatic quiet_check(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(!out_start && !out_bit, tag, {out_start, out_bit}, 0);
      in_start = 1'b0;
      in_bit   = 1'($urandom);
      mcand    = W'($urandom);
    end
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    in_start = 1'b0;
    in_bit   = 1'b0;
    mcand    = '0;
    repeat (4) @(negedge clk);
    chk(!out_start && !out_bit, "R8 outputs during reset", {out_start, out_bit}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_start && !out_bit, "R8 outputs after reset", {out_start, out_bit}, 0);

    // R1 R5: directed table, back to back (R4)
    for (int i = 0; i < NV; i++) send_word(VEC[i][15:8], VEC[i][7:0]);

    // R1 R2 R4: random words, mostly back to back
    for (int i = 0; i < 40; i++) begin
      send_word(W'($urandom), W'($urandom));
      if (i % 5 == 4) idle(3);
    end
    idle(W + 2);
    chk(n_recv == n_sent, "R4 every word delivered", n_recv, n_sent);

    // R6 R9: stream with no open word
    quiet_check(3 * W, "R6 R9 idle stream ignored");

    // R7: restart partway through a word
    send_partial(3);
    send_word(8'h7F, 8'h81);
    idle(W + 2);
    chk(n_recv == n_sent, "R7 only restarted word delivered", n_recv, n_sent);

    // R7: restart in the last-bit position
    send_partial(W - 1);
    send_word(8'hC3, 8'h80);
    idle(W + 2);
    chk(n_recv == n_sent, "R7 late restart", n_recv, n_sent);

    // R8: reset during an open word
    send_partial(4);
    @(negedge clk);
    rst = 1'b1;
    in_start = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    quiet_check(2 * W, "R8 word cut by reset");
    chk(n_recv == n_sent, "R8 no extra word", n_recv, n_sent);

    // R1: one more word after reset
    send_word(8'h80, 8'h80);
    idle(W + 2);
    chk(n_recv == n_sent, "R1 word after reset delivered", n_recv, n_sent);

    summary();
    $finish;
  end
endmodule